// File: doc/BRIEF.md
# Interrupt Event and Mask Register

This block holds the sticky interrupt status of a serial-bus link controller, with a companion mask. Each of the 32 event bits can be raised by a one-cycle hardware pulse on `hw_evt`. Software raises bits by writing ones to a set alias and lowers them by writing ones to a clear alias. The mask has its own set and clear aliases. One interrupt line goes high while any unmasked event is pending, provided the master enable in mask bit 31 is on.

Two couplings are built in. First, a hardware bus-reset event (bit 17) drops the self-ID-done bit (bit 16) in the same cycle. Second, when software clears the PHY interrupt bit (bit 19), the block sends a one-cycle pulse on `phy_src_clr`. That pulse clears the PHY-side sources behind bit 19: loop detect, cable power fail, arbitration timeout and port event.

The other hardware sources sit at fixed positions. Bit 27 means a PHY register read is done. Bits 25 down to 20 are, in order: cycle too long, unrecoverable error, cycle inconsistent, cycle lost, 64-second tick and cycle synch. Bit 29 is a software-only interrupt.

Reads go through a simple strobe, and the data appears one cycle later. Reading the clear alias returns the events gated by the mask, not the raw events. The reset input asserts asynchronously and is released synchronously inside the block.

Top module: `irq_event_regs`

## Requirements
- R1: While reset is asserted and after it is released, every event and mask bit is 0, `irq` is 0 and `phy_src_clr` is 0.
- R2: A one-cycle pulse on a hardware-sourced bit of `hw_evt` sets that event bit at the next clock edge, and the bit stays set after the pulse ends.
- R3: A write to address 0 (event set alias) sets every event bit whose data bit is 1 and leaves the bits written 0 unchanged. Bit 29 can be raised this way.
- R4: A write to address 1 (event clear alias) clears every event bit whose data bit is 1 and leaves the bits written 0 unchanged.
- R5: When a hardware pulse and a clear-alias write target the same event bit in one cycle, the bit ends up set.
- R6: Pulses on `hw_evt` bits 29 and 31 have no effect, because those bits have no hardware source.
- R7: A hardware pulse on bit 17 (bus reset) sets bit 17 and leaves bit 16 (self-ID done) at 0 after that edge, even if bit 16 was set before or was raised in the same cycle.
- R8: A read strobe returns data on `reg_rdata` one cycle later. Address 0 returns the raw events, address 1 returns events AND mask, and addresses 2 and 3 return the mask.
- R9: `irq` equals mask bit 31 AND the OR over bits 30..0 of (events AND mask).
- R10: If a clear-alias write lowers event bit 19 from 1 to 0, `phy_src_clr` is 1 for exactly the following cycle. It stays 0 if bit 19 was already 0, or if a hardware pulse keeps the bit set.
- R11: A write to address 2 sets the mask bits written 1, and a write to address 3 clears them. Bits written 0 are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserts asynchronously and is released synchronously |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; data is returned the next cycle |
| reg_addr | input | 2 | Register select: 0 event set, 1 event clear, 2 mask set, 3 mask clear |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| hw_evt | input | 32 | Hardware event pulses, one bit per event |
| irq | output | 1 | Master interrupt |
| phy_src_clr | output | 1 | One-cycle clear toward the PHY interrupt sources |

## Verification
A corrupted event or mask bit shows up in the read data one cycle after the next read strobe. If that bit is unmasked and the master enable is on, it also shows up on `irq` in the same cycle the bit is stored. A broken bus-reset coupling leaves bit 16 visible in the raw read right after the bit-17 pulse. A wrong PHY-clear decision shows up on `phy_src_clr` in the cycle after the clear write, or as a second pulse in the cycle after that. Same-cycle set and clear conflicts are driven directly, so a wrong priority is seen at the very next read.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;
   typedef enum logic [1:0] {
      ADDR_EVT_SET = 2'd0,
      ADDR_EVT_CLR = 2'd1,
      ADDR_MSK_SET = 2'd2,
      ADDR_MSK_CLR = 2'd3
   } reg_addr_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n_in,
   output logic rst_n_out
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n_in) begin
      if (!rst_n_in) chain <= '0;
      else           chain <= {chain[STAGES-2:0], 1'b1};
   end

   assign rst_n_out = chain[STAGES-1];

   if (STAGES < 2) begin : g_bad_stages
      $error("irq_rst_sync: STAGES must be at least 2");
   end
endmodule

// File: rtl/irq_evt_bank.sv
module irq_evt_bank #(
   parameter int          W           = 32,
   parameter logic [W-1:0] HW_SRC     = '1,
   parameter int          BUSRST_BIT  = 17,
   parameter int          SIDDONE_BIT = 16,
   parameter int          PHY_BIT     = 19,
   parameter int          SOFT_BIT    = 29
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] hw_evt,
   input  logic [W-1:0] sw_set,
   input  logic [W-1:0] sw_clr,
   output logic [W-1:0] evt,
   output logic         phy_src_clr
);
   localparam logic [W-1:0] SID_MASK = W'(1) << SIDDONE_BIT;

   logic [W-1:0] hw_set;
   logic [W-1:0] nxt;
   logic         phy_drop;

   for (genvar i = 0; i < W; i++) begin : g_src
      if (HW_SRC[i]) begin : g_hw
         assign hw_set[i] = hw_evt[i];
      end else begin : g_sw_only
         logic sink_unused;
         assign sink_unused = hw_evt[i];
         assign hw_set[i]   = 1'b0;
      end
   end

   always_comb begin
      nxt = (evt & ~sw_clr) | sw_set | hw_set;
      if (hw_set[BUSRST_BIT]) nxt[SIDDONE_BIT] = 1'b0;
   end

   assign phy_drop = evt[PHY_BIT] & sw_clr[PHY_BIT] & ~nxt[PHY_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt         <= '0;
         phy_src_clr <= 1'b0;
      end else begin
         evt         <= nxt;
         phy_src_clr <= phy_drop;
      end
   end

   // R2
   hw_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|hw_set) |=> ((evt & $past(hw_set) & ~SID_MASK) == ($past(hw_set) & ~SID_MASK)));

   // R7
   busrst_sid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hw_evt[BUSRST_BIT] |=> !evt[SIDDONE_BIT]);

   // R6
   soft_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_set[SOFT_BIT] |=> !$rose(evt[SOFT_BIT]));

   // R10
   phy_pulse_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phy_src_clr |-> !evt[PHY_BIT]);

   // R10
   phy_pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phy_src_clr |=> !phy_src_clr);
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sw_set,
   input  logic [W-1:0] sw_clr,
   output logic [W-1:0] msk
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) msk <= '0;
      else        msk <= (msk & ~sw_clr) | sw_set;
   end

   // R11
   msk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|sw_set) |=> ((msk & $past(sw_set)) == $past(sw_set)));

   // R11
   msk_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|sw_clr) && ((sw_clr & sw_set) == '0)) |=> ((msk & $past(sw_clr)) == '0));
endmodule

// File: rtl/irq_rd_path.sv
module irq_rd_path
   import irq_evt_pkg::*;
#(
   parameter int W             = 32,
   parameter int MASTER_BIT    = 31,
   parameter bit USE_MASTER_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rd_en,
   input  reg_addr_e    addr,
   input  logic [W-1:0] evt,
   input  logic [W-1:0] msk,
   output logic [W-1:0] rdata,
   output logic         irq
);
   localparam logic [W-1:0] SRC_BITS = ~(W'(1) << MASTER_BIT);

   logic [W-1:0] gated;
   logic         any_pend;

   assign gated    = evt & msk;
   assign any_pend = |(gated & SRC_BITS);

   if (USE_MASTER_EN) begin : g_master
      assign irq = any_pend & msk[MASTER_BIT];
   end else begin : g_no_master
      assign irq = any_pend;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (rd_en) begin
         unique case (addr)
            ADDR_EVT_SET: rdata <= evt;
            ADDR_EVT_CLR: rdata <= gated;
            default:      rdata <= msk;
         endcase
      end
   end

   // R9
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((evt & msk & SRC_BITS) != '0));

   // R9
   if (USE_MASTER_EN) begin : g_master_chk
      irq_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq |-> msk[MASTER_BIT]);
   end
endmodule

// File: rtl/irq_event_regs.sv
module irq_event_regs
   import irq_evt_pkg::*;
#(
   parameter int           W           = 32,
   parameter logic [W-1:0] HW_SRC      = W'(32'h5FFF_FFFF),
   parameter int           BUSRST_BIT  = 17,
   parameter int           SIDDONE_BIT = 16,
   parameter int           PHY_BIT     = 19,
   parameter int           SOFT_BIT    = 29,
   parameter int           MASTER_BIT  = 31,
   parameter int           SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         reg_wr,
   input  logic         reg_rd,
   input  logic [1:0]   reg_addr,
   input  logic [W-1:0] reg_wdata,
   output logic [W-1:0] reg_rdata,
   input  logic [W-1:0] hw_evt,
   output logic         irq,
   output logic         phy_src_clr
);
   if (BUSRST_BIT >= W || SIDDONE_BIT >= W || PHY_BIT >= W ||
       SOFT_BIT >= W || MASTER_BIT >= W) begin : g_bad_pos
      $error("irq_event_regs: bit position outside the register width");
   end
   if (BUSRST_BIT == SIDDONE_BIT || PHY_BIT == BUSRST_BIT ||
       PHY_BIT == SIDDONE_BIT) begin : g_bad_overlap
      $error("irq_event_regs: coupled bits must be distinct");
   end
   if (HW_SRC[SOFT_BIT]) begin : g_bad_soft
      $error("irq_event_regs: software-only bit must have no hardware source");
   end

   reg_addr_e    addr;
   logic         rst_i;
   logic [W-1:0] evt_set, evt_clr, msk_set, msk_clr;
   logic [W-1:0] evt, msk;

   assign addr    = reg_addr_e'(reg_addr);
   assign evt_set = (reg_wr && addr == ADDR_EVT_SET) ? reg_wdata : '0;
   assign evt_clr = (reg_wr && addr == ADDR_EVT_CLR) ? reg_wdata : '0;
   assign msk_set = (reg_wr && addr == ADDR_MSK_SET) ? reg_wdata : '0;
   assign msk_clr = (reg_wr && addr == ADDR_MSK_CLR) ? reg_wdata : '0;

   irq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
      .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_i)
   );

   irq_evt_bank #(
      .W(W), .HW_SRC(HW_SRC), .BUSRST_BIT(BUSRST_BIT),
      .SIDDONE_BIT(SIDDONE_BIT), .PHY_BIT(PHY_BIT), .SOFT_BIT(SOFT_BIT)
   ) u_evt (
      .clk(clk), .rst_n(rst_i), .hw_evt(hw_evt), .sw_set(evt_set),
      .sw_clr(evt_clr), .evt(evt), .phy_src_clr(phy_src_clr)
   );

   irq_mask_bank #(.W(W)) u_msk (
      .clk(clk), .rst_n(rst_i), .sw_set(msk_set), .sw_clr(msk_clr), .msk(msk)
   );

   irq_rd_path #(.W(W), .MASTER_BIT(MASTER_BIT), .USE_MASTER_EN(1'b1)) u_rd (
      .clk(clk), .rst_n(rst_i), .rd_en(reg_rd), .addr(addr), .evt(evt),
      .msk(msk), .rdata(reg_rdata), .irq(irq)
   );

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_i |-> (!irq && !phy_src_clr));
endmodule

// File: tb/irq_event_regs_bench.sv
module irq_event_regs_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0, hw_evt = '0;
   logic [31:0] reg_rdata;
   logic        irq, phy_src_clr;

   int total = 0;
   int bad = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #2 clk = ~clk;

   irq_event_regs u_irq_event_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .hw_evt(hw_evt), .irq(irq), .phy_src_clr(phy_src_clr)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic pulse(input logic [31:0] d);
      hw_evt = d;
      @(negedge clk);
      hw_evt = '0;
   endtask

   task automatic rd_exp(input logic [1:0] a, input logic [31:0] e, input string tag);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   // monitor: pops one expected item per read strobe taken at a rising edge
   initial begin
      forever begin
         logic took;
         @(posedge clk);
         took = reg_rd;
         @(negedge clk);
         if (took) begin
            if (exp_q.size() == 0) begin
               chk("R8 unexpected read", reg_rdata, 32'hx);
            end else begin
               logic [31:0] e;
               string       t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(t, reg_rdata, e);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 irq in reset", {31'd0, irq}, 32'd0);
      chk("R1 phy clr in reset", {31'd0, phy_src_clr}, 32'd0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      rd_exp(2'd0, 32'h0, "R1 events after reset");
      rd_exp(2'd2, 32'h0, "R1 mask after reset");
      chk("R1 irq after reset", {31'd0, irq}, 32'd0);

      pulse(32'h0810_0000);
      @(negedge clk);
      rd_exp(2'd0, 32'h0810_0000, "R2 hw bits sticky");

      pulse(32'hA000_0000);
      rd_exp(2'd0, 32'h0810_0000, "R6 sw-only bits ignore hw");

      wr(2'd0, 32'h2000_0001);
      rd_exp(2'd0, 32'h2810_0001, "R3 set alias");

      wr(2'd1, 32'h0800_0000);
      rd_exp(2'd0, 32'h2010_0001, "R4 clear alias");

      wr(2'd2, 32'h0010_0000);
      chk("R9 no master enable", {31'd0, irq}, 32'd0);
      rd_exp(2'd3, 32'h0010_0000, "R11 mask set");
      wr(2'd2, 32'h8000_0000);
      chk("R9 master enable", {31'd0, irq}, 32'd1);
      rd_exp(2'd1, 32'h0010_0000, "R8 clear alias reads gated");
      rd_exp(2'd0, 32'h2010_0001, "R8 set alias reads raw");
      wr(2'd3, 32'h0010_0000);
      chk("R9 source unmasked", {31'd0, irq}, 32'd0);
      rd_exp(2'd2, 32'h8000_0000, "R11 mask clear");

      hw_evt = 32'h0000_0001; reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h0000_0001;
      @(negedge clk);
      hw_evt = '0; reg_wr = 1'b0; reg_wdata = '0;
      rd_exp(2'd0, 32'h2010_0001, "R5 hw set beats clear");
      wr(2'd1, 32'h0000_0001);
      rd_exp(2'd0, 32'h2010_0000, "R4 plain clear");

      wr(2'd0, 32'h0001_0000);
      rd_exp(2'd0, 32'h2011_0000, "R3 self-id set");
      pulse(32'h0002_0000);
      rd_exp(2'd0, 32'h2012_0000, "R7 bus reset drops self-id");
      pulse(32'h0003_0000);
      rd_exp(2'd0, 32'h2012_0000, "R7 same-cycle self-id");

      pulse(32'h0008_0000);
      rd_exp(2'd0, 32'h201A_0000, "R2 phy bit");
      wr(2'd1, 32'h0008_0000);
      chk("R10 phy clr pulse", {31'd0, phy_src_clr}, 32'd1);
      @(negedge clk);
      chk("R10 phy clr one cycle", {31'd0, phy_src_clr}, 32'd0);
      rd_exp(2'd0, 32'h2012_0000, "R10 phy bit cleared");
      wr(2'd1, 32'h0008_0000);
      chk("R10 no pulse when already clear", {31'd0, phy_src_clr}, 32'd0);
      hw_evt = 32'h0008_0000; reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h0008_0000;
      @(negedge clk);
      hw_evt = '0; reg_wr = 1'b0; reg_wdata = '0;
      chk("R10 no pulse when hw keeps bit", {31'd0, phy_src_clr}, 32'd0);
      rd_exp(2'd0, 32'h201A_0000, "R5 phy bit kept");

      wr(2'd2, 32'h0008_0000);
      chk("R9 phy pending irq", {31'd0, irq}, 32'd1);
      rd_exp(2'd1, 32'h0008_0000, "R8 gated read");

      repeat (2) @(negedge clk);
      chk("R8 all reads answered", exp_q.size(), 32'd0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule